// File: doc/BRIEF.md
# Unlock-Sequenced Flash Command Decoder

This block sits behind the asynchronous bus of a parallel flash device and turns its write cycles into decoded instructions for the program/erase engine. The chip-enable, write-enable and output-enable strobes are brought into the system clock domain. A write is taken as the window in which all three strobes are in the write state. The address is captured when that window opens, which is the later of the two enable falling edges. The data is captured when the window closes, which is the earlier of the two rising edges.

Every instruction that changes the array must be preceded by a fixed two-write unlock code. Erase needs a second unlock code before its confirm write. The unlock addresses differ between byte-wide and word-wide operation. Any write that breaks a sequence sends the block back to read-array mode and issues nothing. Accepted instructions come out as one-cycle pulses that carry an operation code, the byte-granular target address and the write data. The block also reports whether reads should come from the array or from the identification space, and it computes the identification answer for the address currently on the bus.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset the block is in read-array mode (`rd_autosel`=0) and issues no pulse until a complete instruction has been written.
- R2: The unlock code is data AAh then 55h (low byte only), written to word addresses 5555h then 2AAAh in word mode. In byte mode it goes to byte addresses AAAAh then 5555h, where the byte address is {addr[14:0], addr_lsb}. addr[15] is ignored in both modes.
- R3: Unlock followed by 90h at the first unlock address issues an AUTOSEL pulse (code 7) and enters identification mode (`rd_autosel`=1).
- R4: Unlock, then A0h at the first unlock address, then one further write issues PROGRAM (code 2). `cmd_addr` is {addr, addr_lsb} in byte mode and {0, addr} in word mode. `cmd_data` is the full word in word mode and {00h, low byte} in byte mode. The data of this write is never taken as a command.
- R5: Unlock, 80h at the first unlock address, then a second unlock, then a final write selects the erase. 30h at any address gives BLK_ERASE (code 3) with that address. 10h at the first unlock address gives CHIP_ERASE (code 4).
- R6: Directly after a block erase, each further 30h write issues another BLK_ERASE with its own address and needs no unlock.
- R7: F0h at any address and in any state except the program data write issues RESET (code 1) and returns to read-array mode. This includes the write just after an unlock code.
- R8: A wrong data value or wrong address anywhere in a sequence abandons it with no pulse. The next write is then decoded from read-array mode.
- R9: From read-array mode, with no unlock, B0h at any address issues SUSPEND (code 5) and 30h issues RESUME (code 6). B0h right after a block erase also issues SUSPEND.
- R10: The address comes from the later enable falling edge and the data from the earlier rising edge. A cycle with `oe_n` low is not a write.
- R11: Every command pulse lasts exactly one clock and carries a code other than NONE (0).
- R12: `as_code` reflects addr[1:0]. 00 gives 20h, 01 gives D0h (top-boot layout, D1h otherwise), 10 gives 01h if `prot_map[addr[15:12]]` is set and 00h otherwise, and 11 gives 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| byte_mode | input | 1 | 1 = byte-wide bus, 0 = word-wide bus |
| addr | input | 16 | Word address lines |
| addr_lsb | input | 1 | Extra byte-select address bit in byte mode |
| data_in | input | 16 | Write data bus |
| prot_map | input | 16 | Protection flag per 4K-word address region |
| cmd_valid | output | 1 | One-cycle instruction pulse |
| cmd_code | output | 3 | Instruction code |
| cmd_addr | output | 17 | Byte-granular target address |
| cmd_data | output | 16 | Write data of the instruction |
| rd_autosel | output | 1 | 1 = reads return identification data |
| as_code | output | 8 | Identification answer for the current address |

## Verification
The bench goes after the mode-dependent unlock addresses with the ignored top bit randomised. A decoder that compared the wrong bit range would miss instructions in one mode or the other. It breaks sequences halfway to confirm that a stray write leaves nothing armed; a decoder that kept partial state would fire a program pulse on a later plain write. It pulls the two enables apart in time to show that address and data come from the correct edges, and it writes F0h as program data to confirm that the data write is never decoded as a reset. It also runs extra block confirms, suspend and resume without unlock, and a write attempt with output enable low, which must leave identification mode untouched.

// File: rtl/fci_pkg.sv
package fci_pkg;

    localparam int ADDR_W   = 16;
    localparam int DATA_W   = 16;
    localparam int CODE_W   = 8;

    localparam logic [CODE_W-1:0] K_UNLOCK_A = 8'hAA;
    localparam logic [CODE_W-1:0] K_UNLOCK_B = 8'h55;
    localparam logic [CODE_W-1:0] K_IDENT    = 8'h90;
    localparam logic [CODE_W-1:0] K_PROGRAM  = 8'hA0;
    localparam logic [CODE_W-1:0] K_ERASE    = 8'h80;
    localparam logic [CODE_W-1:0] K_BLOCK    = 8'h30;
    localparam logic [CODE_W-1:0] K_CHIP     = 8'h10;
    localparam logic [CODE_W-1:0] K_HALT     = 8'hB0;
    localparam logic [CODE_W-1:0] K_ABORT    = 8'hF0;

    localparam logic [CODE_W-1:0] MAKER_ID   = 8'h20;
    localparam logic [CODE_W-1:0] PART_TOP   = 8'hD0;
    localparam logic [CODE_W-1:0] PART_BOT   = 8'hD1;

    typedef enum logic [2:0] {
        OP_NONE       = 3'd0,
        OP_RESET      = 3'd1,
        OP_PROGRAM    = 3'd2,
        OP_BLK_ERASE  = 3'd3,
        OP_CHIP_ERASE = 3'd4,
        OP_SUSPEND    = 3'd5,
        OP_RESUME     = 3'd6,
        OP_AUTOSEL    = 3'd7
    } op_e;

    typedef enum logic [3:0] {
        S_READ, S_UL1, S_UL2, S_IDENT, S_PGM,
        S_ESET, S_EUL1, S_EUL2, S_EMORE
    } seq_e;

    typedef struct packed {
        logic              byte_mode;
        logic [ADDR_W:0]   baddr;     // {addr, addr_lsb}
        logic [DATA_W-1:0] data;
    } bus_wr_t;

    // Unlock address match; bits above 14 of the word address are ignored.
    function automatic logic unlock_hit(input logic byte_mode,
                                        input logic [ADDR_W:0] baddr,
                                        input logic second);
        logic [15:0] byte_key;
        logic [14:0] word_key;
        byte_key = second ? 16'h5555 : 16'hAAAA;
        word_key = second ? 15'h2AAA : 15'h5555;
        if (byte_mode)
            return baddr[15:0] == byte_key;
        else
            return baddr[15:1] == word_key;
    endfunction

endpackage

// File: rtl/fci_strobe.sv
module fci_strobe
    import fci_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              byte_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic              addr_lsb,
    input  logic [DATA_W-1:0] data_in,
    output logic              wr_vld,
    output bus_wr_t           wr
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] ce_q, we_q, oe_q;
    logic                   act, act_d;
    logic [ADDR_W:0]        hold_addr;
    logic                   hold_byte;

    always_ff @(posedge clk) begin
        if (rst) begin
            ce_q <= '1;
            we_q <= '1;
            oe_q <= '1;
        end else begin
            ce_q <= {ce_q[TOP-1:0], ce_n};
            we_q <= {we_q[TOP-1:0], we_n};
            oe_q <= {oe_q[TOP-1:0], oe_n};
        end
    end

    // Write window: both enables low while outputs are disabled.
    assign act = !ce_q[TOP] && !we_q[TOP] && oe_q[TOP];

    always_ff @(posedge clk) begin
        if (rst) begin
            act_d     <= 1'b0;
            wr_vld    <= 1'b0;
            hold_addr <= '0;
            hold_byte <= 1'b0;
            wr        <= '0;
        end else begin
            act_d  <= act;
            wr_vld <= 1'b0;
            if (act && !act_d) begin
                hold_addr <= {addr, addr_lsb};
                hold_byte <= byte_mode;
            end
            if (!act && act_d) begin
                wr_vld       <= 1'b1;
                wr.baddr     <= hold_addr;
                wr.byte_mode <= hold_byte;
                wr.data      <= data_in;
            end
        end
    end
endmodule

// File: rtl/fci_seq.sv
module fci_seq
    import fci_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_vld,
    input  bus_wr_t           wr,
    output logic              cmd_valid,
    output op_e               cmd_op,
    output logic [ADDR_W:0]   cmd_addr,
    output logic [DATA_W-1:0] cmd_data,
    output logic              ident_mode
);
    seq_e              state, nxt;
    op_e               op;
    logic [CODE_W-1:0] d;
    logic              ul_a, ul_b;

    assign d    = wr.data[CODE_W-1:0];
    assign ul_a = unlock_hit(wr.byte_mode, wr.baddr, 1'b0);
    assign ul_b = unlock_hit(wr.byte_mode, wr.baddr, 1'b1);

    always_comb begin
        nxt = state;
        op  = OP_NONE;
        if (wr_vld) begin
            if (state != S_PGM && d == K_ABORT) begin
                nxt = S_READ;
                op  = OP_RESET;
            end else begin
                unique case (state)
                    S_READ, S_IDENT, S_EMORE: begin
                        nxt = S_READ;
                        if (d == K_UNLOCK_A && ul_a)
                            nxt = S_UL1;
                        else if (state != S_IDENT && d == K_HALT)
                            op = OP_SUSPEND;
                        else if (state == S_EMORE && d == K_BLOCK) begin
                            op  = OP_BLK_ERASE;
                            nxt = S_EMORE;
                        end else if (state == S_READ && d == K_BLOCK)
                            op = OP_RESUME;
                    end
                    S_UL1:  nxt = (d == K_UNLOCK_B && ul_b) ? S_UL2 : S_READ;
                    S_UL2: begin
                        nxt = S_READ;
                        if (ul_a && d == K_IDENT) begin
                            nxt = S_IDENT;
                            op  = OP_AUTOSEL;
                        end else if (ul_a && d == K_PROGRAM)
                            nxt = S_PGM;
                        else if (ul_a && d == K_ERASE)
                            nxt = S_ESET;
                    end
                    S_PGM: begin
                        nxt = S_READ;
                        op  = OP_PROGRAM;
                    end
                    S_ESET: nxt = (d == K_UNLOCK_A && ul_a) ? S_EUL1 : S_READ;
                    S_EUL1: nxt = (d == K_UNLOCK_B && ul_b) ? S_EUL2 : S_READ;
                    S_EUL2: begin
                        nxt = S_READ;
                        if (d == K_BLOCK) begin
                            nxt = S_EMORE;
                            op  = OP_BLK_ERASE;
                        end else if (d == K_CHIP && ul_a)
                            op = OP_CHIP_ERASE;
                    end
                    default: nxt = S_READ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_READ;
            cmd_valid <= 1'b0;
            cmd_op    <= OP_NONE;
            cmd_addr  <= '0;
            cmd_data  <= '0;
        end else begin
            state     <= nxt;
            cmd_valid <= (op != OP_NONE);
            cmd_op    <= op;
            if (op != OP_NONE) begin
                cmd_addr <= wr.byte_mode ? wr.baddr : {1'b0, wr.baddr[ADDR_W:1]};
                cmd_data <= wr.byte_mode ? {{(DATA_W-CODE_W){1'b0}}, d} : wr.data;
            end
        end
    end

    assign ident_mode = (state == S_IDENT);
endmodule

// File: rtl/fci_ident.sv
module fci_ident
    import fci_pkg::*;
#(
    parameter bit TOP_BOOT = 1'b1,
    parameter int REGIONS  = 16,
    localparam int RB      = $clog2(REGIONS)
) (
    input  logic [1:0]         sel,
    input  logic [RB-1:0]      region,
    input  logic [REGIONS-1:0] prot_map,
    output logic [CODE_W-1:0]  code
);
    localparam logic [CODE_W-1:0] PART = TOP_BOOT ? PART_TOP : PART_BOT;

    always_comb begin
        unique case (sel)
            2'b00:   code = MAKER_ID;
            2'b01:   code = PART;
            2'b10:   code = {{(CODE_W-1){1'b0}}, prot_map[region]};
            default: code = '0;
        endcase
    end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import fci_pkg::*;
#(
    parameter bit TOP_BOOT    = 1'b1,
    parameter int REGIONS     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ce_n,
    input  logic                we_n,
    input  logic                oe_n,
    input  logic                byte_mode,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                addr_lsb,
    input  logic [DATA_W-1:0]   data_in,
    input  logic [REGIONS-1:0]  prot_map,
    output logic                cmd_valid,
    output logic [2:0]          cmd_code,
    output logic [ADDR_W:0]     cmd_addr,
    output logic [DATA_W-1:0]   cmd_data,
    output logic                rd_autosel,
    output logic [CODE_W-1:0]   as_code
);
    localparam int RB = $clog2(REGIONS);

    logic    wr_vld;
    bus_wr_t wr;
    op_e     op;

    fci_strobe #(.SYNC_STAGES(SYNC_STAGES)) u_strobe (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .byte_mode(byte_mode), .addr(addr), .addr_lsb(addr_lsb),
        .data_in(data_in), .wr_vld(wr_vld), .wr(wr)
    );

    fci_seq u_seq (
        .clk(clk), .rst(rst), .wr_vld(wr_vld), .wr(wr),
        .cmd_valid(cmd_valid), .cmd_op(op), .cmd_addr(cmd_addr),
        .cmd_data(cmd_data), .ident_mode(rd_autosel)
    );

    fci_ident #(.TOP_BOOT(TOP_BOOT), .REGIONS(REGIONS)) u_ident (
        .sel(addr[1:0]), .region(addr[ADDR_W-1 -: RB]),
        .prot_map(prot_map), .code(as_code)
    );

    assign cmd_code = op;
endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk (
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid,
    input logic [2:0] cmd_code,
    input logic       rd_autosel
);
    // R11
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);

    // R11
    valid_op_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> cmd_code != 3'd0);

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!cmd_valid && !rd_autosel));

    // R3
    autosel_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_autosel) |-> (cmd_valid && cmd_code == 3'd7));

    // R7
    reset_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_code == 3'd1) |-> !rd_autosel);
endmodule

bind flash_cmd_decoder flash_cmd_chk u_chk (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .rd_autosel(rd_autosel)
);

// File: tb/flash_cmd_decoder_bench.sv
module flash_cmd_decoder_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic        byte_mode = 1'b0;
    logic [15:0] addr = '0;
    logic        addr_lsb = 1'b0;
    logic [15:0] data_in = '0;
    logic [15:0] prot_map = 16'hA5C3;
    logic        cmd_valid;
    logic [2:0]  cmd_code;
    logic [16:0] cmd_addr;
    logic [15:0] cmd_data;
    logic        rd_autosel;
    logic [7:0]  as_code;

    int checks = 0;
    int errors = 0;
    int n_cmd  = 0;
    logic [2:0]  last_code;
    logic [16:0] last_addr;
    logic [15:0] last_data;

    always #4 clk = ~clk;

    flash_cmd_decoder u_flash_cmd_decoder (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .byte_mode(byte_mode), .addr(addr), .addr_lsb(addr_lsb),
        .data_in(data_in), .prot_map(prot_map), .cmd_valid(cmd_valid),
        .cmd_code(cmd_code), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .rd_autosel(rd_autosel), .as_code(as_code)
    );

    always @(negedge clk) begin
        if (!rst && cmd_valid) begin
            n_cmd     <= n_cmd + 1;
            last_code <= cmd_code;
            last_addr <= cmd_addr;
            last_data <= cmd_data;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] a, input logic m1, input logic [15:0] d);
        @(negedge clk);
        addr = a; addr_lsb = m1; data_in = d; oe_n = 1'b1;
        ce_n = 1'b0; we_n = 1'b0;
        idle(6);
        ce_n = 1'b1; we_n = 1'b1;
        idle(6);
    endtask

    // Unlock address as {word address, lsb}, addr[15] randomised (R2).
    function automatic logic [16:0] ul_ba(input logic bm, input logic second);
        logic [16:0] r;
        r = second ? {16'h2AAA, bm} : {16'h5555, 1'b0};
        r[16] = 1'($urandom);
        return r;
    endfunction

    task automatic wr_ul(input logic second, input logic [7:0] code);
        logic [16:0] u;
        u = ul_ba(byte_mode, second);
        wr(u[16:1], u[0], {8'($urandom), code});
    endtask

    task automatic unlock();
        wr_ul(1'b0, 8'hAA);
        wr_ul(1'b1, 8'h55);
    endtask

    task automatic cmd3(input logic [7:0] code);
        unlock();
        wr_ul(1'b0, code);
    endtask

    function automatic logic [16:0] exp_addr(input logic bm, input logic [15:0] a, input logic m1);
        return bm ? {a, m1} : {1'b0, a};
    endfunction

    function automatic logic [15:0] exp_data(input logic bm, input logic [15:0] d);
        return bm ? {8'h00, d[7:0]} : d;
    endfunction

    function automatic logic [7:0] exp_as(input logic [15:0] a);
        case (a[1:0])
            2'b00:   return 8'h20;
            2'b01:   return 8'hD0;
            2'b10:   return {7'd0, prot_map[a[15:12]]};
            default: return 8'h00;
        endcase
    endfunction

    task automatic expect_op(input string req, input int n0, input logic [2:0] code);
        chk({req, " pulse count"}, n_cmd, n0 + 1);
        chk({req, " code"}, {29'd0, last_code}, {29'd0, code});
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int n0;
        logic [15:0] a, d;
        logic m1;
        void'($urandom(32'h5EED));
        idle(4);
        rst = 1'b0;
        idle(4);
        // R1: reset state
        chk("R1 rd_autosel", {31'd0, rd_autosel}, 0);
        chk("R1 cmd_valid", {31'd0, cmd_valid}, 0);
        chk("R1 no pulse", n_cmd, 0);

        // R4, R2: word program
        byte_mode = 1'b0; n0 = n_cmd;
        cmd3(8'hA0); wr(16'h8123, 1'b0, 16'hBEEF);
        expect_op("R4 word program", n0, 3'd2);
        chk("R4 word addr", {15'd0, last_addr}, {15'd0, exp_addr(0, 16'h8123, 0)});
        chk("R4 word data", {16'd0, last_data}, {16'd0, 16'hBEEF});

        // R4, R2: byte program, data F0 not taken as reset
        byte_mode = 1'b1; n0 = n_cmd;
        cmd3(8'hA0); wr(16'h0456, 1'b1, 16'h77F0);
        expect_op("R4 byte program", n0, 3'd2);
        chk("R4 byte addr", {15'd0, last_addr}, {15'd0, exp_addr(1, 16'h0456, 1)});
        chk("R4 byte data", {16'd0, last_data}, {16'd0, exp_data(1, 16'h77F0)});

        // R2: word-mode unlock addresses used in byte mode do not unlock
        byte_mode = 1'b1; n0 = n_cmd;
        wr(16'h5555, 1'b0, 16'h00AA); wr(16'h2AAA, 1'b0, 16'h0055);
        wr(16'h5555, 1'b0, 16'h00A0); wr(16'h1000, 1'b0, 16'h0011);
        chk("R2 byte mode rejects word addresses", n_cmd, n0);

        // R3, R12: autoselect
        byte_mode = 1'b0; n0 = n_cmd;
        cmd3(8'h90);
        expect_op("R3 autoselect", n0, 3'd7);
        chk("R3 rd_autosel", {31'd0, rd_autosel}, 1);
        for (int i = 0; i < 6; i++) begin
            a = 16'($urandom);
            @(negedge clk); addr = a; idle(1);
            chk("R12 ident code", {24'd0, as_code}, {24'd0, exp_as(a)});
        end
        @(negedge clk); addr = 16'hF002; idle(1);
        chk("R12 protected region", {24'd0, as_code}, 32'h01);
        @(negedge clk); addr = 16'h3002; idle(1);
        chk("R12 unprotected region", {24'd0, as_code}, 32'h00);

        // R10: write with oe_n low is ignored
        n0 = n_cmd;
        @(negedge clk); addr = 16'h1234; data_in = 16'h00F0; oe_n = 1'b0;
        ce_n = 1'b0; we_n = 1'b0; idle(6); ce_n = 1'b1; we_n = 1'b1; idle(6);
        oe_n = 1'b1;
        chk("R10 oe low no pulse", n_cmd, n0);
        chk("R10 oe low keeps mode", {31'd0, rd_autosel}, 1);

        // R7: F0 at any address leaves autoselect
        n0 = n_cmd;
        wr(16'h7E31, 1'b0, 16'h12F0);
        expect_op("R7 reset", n0, 3'd1);
        chk("R7 read array", {31'd0, rd_autosel}, 0);

        // R7: unlock then F0
        n0 = n_cmd;
        unlock(); wr(16'h0042, 1'b0, 16'h00F0);
        expect_op("R7 reset after unlock", n0, 3'd1);

        // R5, R6, R9: block erase, extra block, suspend, resume
        byte_mode = 1'b0; n0 = n_cmd;
        cmd3(8'h80); unlock(); wr(16'h4000, 1'b0, 16'h0030);
        expect_op("R5 block erase", n0, 3'd3);
        chk("R5 block addr", {15'd0, last_addr}, {15'd0, 17'h04000});
        n0 = n_cmd;
        wr(16'hC000, 1'b0, 16'h0030);
        expect_op("R6 extra block", n0, 3'd3);
        chk("R6 extra addr", {15'd0, last_addr}, {15'd0, 17'h0C000});
        n0 = n_cmd;
        wr(16'h0777, 1'b0, 16'h00B0);
        expect_op("R9 suspend", n0, 3'd5);
        n0 = n_cmd;
        wr(16'h9999, 1'b0, 16'h0030);
        expect_op("R9 resume", n0, 3'd6);

        // R5: chip erase in byte mode
        byte_mode = 1'b1; n0 = n_cmd;
        cmd3(8'h80); unlock(); wr_ul(1'b0, 8'h10);
        expect_op("R5 chip erase", n0, 3'd4);

        // R8: broken unlock, then a would-be program is plain writes
        byte_mode = 1'b0; n0 = n_cmd;
        wr_ul(1'b0, 8'hAA); wr(16'h2AAB, 1'b0, 16'h0055);
        wr_ul(1'b0, 8'hA0); wr(16'h0100, 1'b0, 16'h1234);
        chk("R8 bad address aborts", n_cmd, n0);
        cmd3(8'h80); wr_ul(1'b0, 8'hAA); wr_ul(1'b1, 8'h54); wr_ul(1'b0, 8'h10);
        chk("R8 bad erase unlock aborts", n_cmd, n0);

        // R10: address from later falling edge, data from earlier rising edge
        n0 = n_cmd;
        cmd3(8'hA0);
        @(negedge clk); addr = 16'h1111; data_in = 16'hAAAA; we_n = 1'b0;
        idle(6); addr = 16'h2222; ce_n = 1'b0;
        idle(6); data_in = 16'h5A5A; idle(6); ce_n = 1'b1;
        idle(6); data_in = 16'h0000; idle(6); we_n = 1'b1; idle(8);
        expect_op("R10 program", n0, 3'd2);
        chk("R10 later falling addr", {15'd0, last_addr}, {15'd0, 17'h02222});
        chk("R10 earlier rising data", {16'd0, last_data}, {16'd0, 16'h5A5A});

        // Random mix
        for (int it = 0; it < 40; it++) begin
            int op;
            op = $urandom_range(0, 4);
            byte_mode = 1'($urandom);
            a = 16'($urandom); m1 = 1'($urandom); d = 16'($urandom);
            n0 = n_cmd;
            case (op)
                0: begin
                    cmd3(8'hA0); wr(a, m1, d);
                    expect_op("R4 random program", n0, 3'd2);
                    chk("R4 random addr", {15'd0, last_addr}, {15'd0, exp_addr(byte_mode, a, m1)});
                    chk("R4 random data", {16'd0, last_data}, {16'd0, exp_data(byte_mode, d)});
                end
                1: begin
                    cmd3(8'h80); unlock(); wr(a, m1, {d[15:8], 8'h30});
                    expect_op("R5 random block erase", n0, 3'd3);
                    chk("R5 random addr", {15'd0, last_addr}, {15'd0, exp_addr(byte_mode, a, m1)});
                end
                2: begin
                    cmd3(8'h80); unlock(); wr_ul(1'b0, 8'h10);
                    expect_op("R5 random chip erase", n0, 3'd4);
                end
                3: begin
                    unlock(); wr(a, m1, {d[15:8], 8'hF0});
                    expect_op("R7 random reset", n0, 3'd1);
                    chk("R7 random mode", {31'd0, rd_autosel}, 0);
                end
                default: begin
                    cmd3(8'h90);
                    expect_op("R3 random autoselect", n0, 3'd7);
                    @(negedge clk); addr = a; idle(1);
                    chk("R12 random ident", {24'd0, as_code}, {24'd0, exp_as(a)});
                end
            endcase
        end
        finish_run();
    end
endmodule